// File: doc/BRIEF.md
# Deferred Floating-Point Exception Unit

This block keeps the error bookkeeping for a coprocessor-style floating-point unit. It records error events in sticky status flags and holds a per-type mask. When an error is masked, it asks the datapath for the default result. When an error is unmasked and native error reporting is on, it does not interrupt the core straight away. It arms a pending exception and keeps the address of the offending instruction. The core is only told about the error when the next waiting-class instruction arrives.

Each cycle the unit receives an instruction class, the instruction address, a vector of error events and a stack-fault event. It also receives a control word for mask loads and the native-reporting enable. Some instruction classes check for a pending exception. Others pass over it: the non-waiting stores and full-state save or restore. Clear and initialize wipe the sticky state. All outputs are registered and change after the rising edge that samples the instruction.

Top module: `fpx_defer_unit`

## Requirements
- R1: After reset, all flags and the stack flag are 0. All mask bits are 1. Pending, default-response, request and both address outputs are 0.
- R2: Error bit order is 0 invalid, 1 denormal, 2 zero-divide, 3 overflow, 4 underflow, 5 precision. Class 1 (arithmetic) with no exception pending sets the flag of every reported error. If any reported error is masked, it pulses `dflt_o` for one cycle in the next cycle.
- R3: Class 1 with no exception pending, `native_en_i` high and at least one reported error whose mask bit is 0 sets `pend_o`. It also loads `fault_ip_o` with that instruction's address, and it raises no request in that cycle.
- R4: Class 1 or class 2 (explicit wait) arriving while `pend_o` is 1 drives `exc_req_o` high for exactly one cycle. It loads `exc_ip_o` with that instruction's address and clears `pend_o`. That instruction's error inputs are ignored.
- R5: Class 3 (non-waiting store/control) and class 4 (full-state save/restore) leave `pend_o`, the flags and the masks unchanged and raise no request. Class 0 (idle) does the same.
- R6: With `native_en_i` low, an unmasked error on class 1 sets its flag but arms no pending state and raises no request.
- R7: Class 5 (clear) zeroes all flags, the stack flag and `pend_o`, and leaves the masks unchanged.
- R8: Class 6 (initialize) zeroes all flags, the stack flag and `pend_o`, and sets every mask bit.
- R9: Class 7 (load control) copies `ctl_i` into the masks and does not touch flags or pending state.
- R10: `stk_i` on an executing class-1 instruction sets `stk_flag_o` and counts as an invalid-operation error (bit 0) for flagging, masking and arming.
- R11: Flags are sticky. Once set, they stay set through requests and every class except 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_cls_i | input | 3 | Instruction class code |
| op_ip_i | input | IP_W | Address of the current instruction |
| err_i | input | NUM_ERR | Error events reported by the datapath |
| stk_i | input | 1 | Stack overflow/underflow event |
| ctl_i | input | NUM_ERR | Mask word for the load-control class |
| native_en_i | input | 1 | Enable for native error reporting |
| flags_o | output | NUM_ERR | Sticky error flags |
| stk_flag_o | output | 1 | Sticky stack-fault flag |
| mask_o | output | NUM_ERR | Current mask bits |
| dflt_o | output | 1 | Default-response pulse |
| pend_o | output | 1 | Exception pending |
| exc_req_o | output | 1 | Deferred exception request pulse |
| exc_ip_o | output | IP_W | Address of the waiting instruction that raised the request |
| fault_ip_o | output | IP_W | Address of the instruction that produced the pending error |

## Verification
Some properties are checked on every cycle. The request is always a single-cycle pulse that follows a pending state. Pending is only armed with native reporting enabled. Flags never drop outside clear and initialize. The bypass classes leave pending and flags untouched. Initialize lands the masks at all ones. Other behaviour only shows in the bench's scenarios, which compare every output against a reference model: the exact values of the two saved addresses, the ignoring of a raising instruction's errors, the mixing of masked and unmasked errors, and how stack faults fold into the invalid bit.

// File: rtl/fpx_defer_pkg.sv
package fpx_defer_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_IDLE   = 3'd0,
      OP_ARITH  = 3'd1,
      OP_WAIT   = 3'd2,
      OP_NOWAIT = 3'd3,
      OP_STATE  = 3'd4,
      OP_CLEAR  = 3'd5,
      OP_INIT   = 3'd6,
      OP_LDCTL  = 3'd7
   } fpx_op_e;

endpackage

// File: rtl/fpx_op_decode.sv
module fpx_op_decode
   import fpx_defer_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   output logic            arith_o,
   output logic            wait_o,
   output logic            clr_o,
   output logic            init_o,
   output logic            ldctl_o
);

   fpx_op_e op;

   always_comb begin
      op      = fpx_op_e'(op_i);
      arith_o = 1'b0;
      wait_o  = 1'b0;
      clr_o   = 1'b0;
      init_o  = 1'b0;
      ldctl_o = 1'b0;
      case (op)
         OP_ARITH: arith_o = 1'b1;
         OP_WAIT:  wait_o  = 1'b1;
         OP_CLEAR: clr_o   = 1'b1;
         OP_INIT: begin
            clr_o  = 1'b1;
            init_o = 1'b1;
         end
         OP_LDCTL: ldctl_o = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank #(
   parameter int NUM_ERR = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ERR-1:0] set_i,
   input  logic               stk_set_i,
   input  logic               clr_i,
   output logic [NUM_ERR-1:0] flags_o,
   output logic               stk_o
);

   for (genvar g = 0; g < NUM_ERR; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flags_o[g] <= 1'b0;
         else if (clr_i)      flags_o[g] <= 1'b0;
         else if (set_i[g])   flags_o[g] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stk_o <= 1'b0;
      else if (clr_i)     stk_o <= 1'b0;
      else if (stk_set_i) stk_o <= 1'b1;
   end

endmodule

// File: rtl/fpx_mask_reg.sv
module fpx_mask_reg #(
   parameter int NUM_ERR = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init_i,
   input  logic               ld_i,
   input  logic [NUM_ERR-1:0] ctl_i,
   output logic [NUM_ERR-1:0] mask_o
);

   localparam logic [NUM_ERR-1:0] ALL_MASKED = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_o <= ALL_MASKED;
      else if (init_i) mask_o <= ALL_MASKED;
      else if (ld_i)   mask_o <= ctl_i;
   end

endmodule

// File: rtl/fpx_pend_ctrl.sv
module fpx_pend_ctrl #(
   parameter int IP_W     = 32,
   parameter bit DFLT_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            raise_i,
   input  logic            arm_i,
   input  logic            drop_i,
   input  logic            dflt_i,
   input  logic [IP_W-1:0] ip_i,
   output logic            pend_o,
   output logic            req_o,
   output logic            dflt_o,
   output logic [IP_W-1:0] exc_ip_o,
   output logic [IP_W-1:0] fault_ip_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_o <= 1'b0;
      else if (drop_i)  pend_o <= 1'b0;
      else if (raise_i) pend_o <= 1'b0;
      else if (arm_i)   pend_o <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_o <= 1'b0;
      else        req_o <= raise_i & ~drop_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 exc_ip_o <= '0;
      else if (raise_i & ~drop_i) exc_ip_o <= ip_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               fault_ip_o <= '0;
      else if (arm_i & ~drop_i) fault_ip_o <= ip_i;
   end

   if (DFLT_REG) begin : g_dflt_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dflt_o <= 1'b0;
         else        dflt_o <= dflt_i;
      end
   end else begin : g_dflt_comb
      assign dflt_o = dflt_i;
   end

endmodule

// File: rtl/fpx_defer_unit.sv
module fpx_defer_unit
   import fpx_defer_pkg::*;
#(
   parameter int NUM_ERR  = 6,
   parameter int INV_IDX  = 0,
   parameter int IP_W     = 32,
   parameter bit DFLT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         op_cls_i,
   input  logic [IP_W-1:0]    op_ip_i,
   input  logic [NUM_ERR-1:0] err_i,
   input  logic               stk_i,
   input  logic [NUM_ERR-1:0] ctl_i,
   input  logic               native_en_i,
   output logic [NUM_ERR-1:0] flags_o,
   output logic               stk_flag_o,
   output logic [NUM_ERR-1:0] mask_o,
   output logic               dflt_o,
   output logic               pend_o,
   output logic               exc_req_o,
   output logic [IP_W-1:0]    exc_ip_o,
   output logic [IP_W-1:0]    fault_ip_o
);

   if (NUM_ERR < 1) begin : g_bad_num
      $error("NUM_ERR must be at least 1");
   end
   if (INV_IDX < 0 || INV_IDX >= NUM_ERR) begin : g_bad_inv
      $error("INV_IDX must index an error bit");
   end
   if (IP_W < 1) begin : g_bad_ip
      $error("IP_W must be at least 1");
   end

   logic               dec_arith, dec_wait, dec_clr, dec_init, dec_ldctl;
   logic [NUM_ERR-1:0] inv_vec;
   logic [NUM_ERR-1:0] eff_err;
   logic [NUM_ERR-1:0] flag_set;
   logic               exec_arith;
   logic               raise;
   logic               arm;
   logic               dflt_req;

   fpx_op_decode u_dec (
      .op_i    (op_cls_i),
      .arith_o (dec_arith),
      .wait_o  (dec_wait),
      .clr_o   (dec_clr),
      .init_o  (dec_init),
      .ldctl_o (dec_ldctl)
   );

   for (genvar g = 0; g < NUM_ERR; g++) begin : g_inv
      assign inv_vec[g] = (g == INV_IDX) ? stk_i : 1'b0;
   end

   assign eff_err    = err_i | inv_vec;
   assign exec_arith = dec_arith & ~pend_o;
   assign flag_set   = exec_arith ? eff_err : '0;
   assign raise      = pend_o & (dec_arith | dec_wait);
   assign arm        = exec_arith & native_en_i & (|(eff_err & ~mask_o));
   assign dflt_req   = exec_arith & (|(eff_err & mask_o));

   fpx_flag_bank #(.NUM_ERR(NUM_ERR)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (flag_set),
      .stk_set_i (exec_arith & stk_i),
      .clr_i     (dec_clr),
      .flags_o   (flags_o),
      .stk_o     (stk_flag_o)
   );

   fpx_mask_reg #(.NUM_ERR(NUM_ERR)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .init_i (dec_init),
      .ld_i   (dec_ldctl),
      .ctl_i  (ctl_i),
      .mask_o (mask_o)
   );

   fpx_pend_ctrl #(.IP_W(IP_W), .DFLT_REG(DFLT_REG)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .raise_i    (raise),
      .arm_i      (arm),
      .drop_i     (dec_clr),
      .dflt_i     (dflt_req),
      .ip_i       (op_ip_i),
      .pend_o     (pend_o),
      .req_o      (exc_req_o),
      .dflt_o     (dflt_o),
      .exc_ip_o   (exc_ip_o),
      .fault_ip_o (fault_ip_o)
   );

endmodule

// File: rtl/fpx_defer_chk.sv
module fpx_defer_chk
   import fpx_defer_pkg::*;
#(
   parameter int NUM_ERR = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         op_cls_i,
   input logic               native_en_i,
   input logic [NUM_ERR-1:0] flags_o,
   input logic [NUM_ERR-1:0] mask_o,
   input logic               dflt_o,
   input logic               pend_o,
   input logic               exc_req_o
);

   logic is_bypass, is_wipe, is_init;
   assign is_bypass = (op_cls_i == OP_NOWAIT) || (op_cls_i == OP_STATE);
   assign is_wipe   = (op_cls_i == OP_CLEAR) || (op_cls_i == OP_INIT);
   assign is_init   = (op_cls_i == OP_INIT);

   assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req_o |=> !exc_req_o);

   assert_req_after_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req_o |-> $past(pend_o));

   assert_arm_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_o) |-> $past(native_en_i));

   assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !is_wipe |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

   assert_init_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      is_init |=> (mask_o == '1 && flags_o == '0 && !pend_o));

   assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      is_bypass |=> (!exc_req_o && $stable(flags_o) && pend_o == $past(pend_o)));

   assert_dflt_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dflt_o |-> !exc_req_o);

endmodule

bind fpx_defer_unit fpx_defer_chk #(.NUM_ERR(NUM_ERR)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_cls_i    (op_cls_i),
   .native_en_i (native_en_i),
   .flags_o     (flags_o),
   .mask_o      (mask_o),
   .dflt_o      (dflt_o),
   .pend_o      (pend_o),
   .exc_req_o   (exc_req_o)
);

// File: tb/fpx_defer_unit_tb.sv
module fpx_defer_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NE = 6;
   localparam int IW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    op_cls = 3'd0;
   logic [IW-1:0] op_ip = '0;
   logic [NE-1:0] err = '0;
   logic          stk = 1'b0;
   logic [NE-1:0] ctl = '0;
   logic          nen = 1'b1;

   logic [NE-1:0] flags, mask;
   logic          stkf, dflt, pend, req;
   logic [IW-1:0] eip, fip;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference model
   logic [NE-1:0] m_flags, m_mask;
   logic          m_stk, m_dflt, m_pend, m_req;
   logic [IW-1:0] m_eip, m_fip;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpx_defer_unit u_dut (
      .clk(clk), .rst_n(rst_n), .op_cls_i(op_cls), .op_ip_i(op_ip),
      .err_i(err), .stk_i(stk), .ctl_i(ctl), .native_en_i(nen),
      .flags_o(flags), .stk_flag_o(stkf), .mask_o(mask), .dflt_o(dflt),
      .pend_o(pend), .exc_req_o(req), .exc_ip_o(eip), .fault_ip_o(fip)
   );

   function automatic void model_reset();
      m_flags = '0; m_mask = '1; m_stk = 0; m_dflt = 0;
      m_pend = 0; m_req = 0; m_eip = '0; m_fip = '0;
   endfunction

   function automatic void model_step(logic [2:0] c, logic [IW-1:0] ip,
                                      logic [NE-1:0] e, logic s,
                                      logic [NE-1:0] k, logic en);
      logic [NE-1:0] ee;
      ee = e | {{(NE-1){1'b0}}, s};
      m_req = 0; m_dflt = 0;
      case (c)
         3'd1: begin
            if (m_pend) begin
               m_req = 1; m_eip = ip; m_pend = 0;
            end else begin
               m_flags = m_flags | ee;
               if (s) m_stk = 1;
               if ((ee & m_mask) != 0) m_dflt = 1;
               if (((ee & ~m_mask) != 0) && en) begin
                  m_pend = 1; m_fip = ip;
               end
            end
         end
         3'd2: if (m_pend) begin m_req = 1; m_eip = ip; m_pend = 0; end
         3'd5: begin m_flags = '0; m_stk = 0; m_pend = 0; end
         3'd6: begin m_flags = '0; m_stk = 0; m_pend = 0; m_mask = '1; end
         3'd7: m_mask = k;
         default: ;
      endcase
   endfunction

   task automatic compare(string tag);
      n_chk++;
      if (flags !== m_flags || stkf !== m_stk || mask !== m_mask ||
          dflt !== m_dflt || pend !== m_pend || req !== m_req ||
          eip !== m_eip || fip !== m_fip) begin
         n_fail++;
         $display("FAIL %s: act flags=%h stk=%b mask=%h dflt=%b pend=%b req=%b eip=%h fip=%h exp flags=%h stk=%b mask=%h dflt=%b pend=%b req=%b eip=%h fip=%h",
                  tag, flags, stkf, mask, dflt, pend, req, eip, fip,
                  m_flags, m_stk, m_mask, m_dflt, m_pend, m_req, m_eip, m_fip);
      end
   endtask

   task automatic step(logic [2:0] c, logic [IW-1:0] ip, logic [NE-1:0] e,
                       logic s, logic [NE-1:0] k, logic en, string tag);
      op_cls = c; op_ip = ip; err = e; stk = s; ctl = k; nen = en;
      @(posedge clk);
      model_step(c, ip, e, s, k, en);
      @(negedge clk);
      compare(tag);
   endtask

   function automatic string tag_of(logic [2:0] c);
      case (c)
         3'd1: return "R2/R3/R4 arith";
         3'd2: return "R4 wait";
         3'd3, 3'd4, 3'd0: return "R5 bypass";
         3'd5: return "R7 clear";
         3'd6: return "R8 init";
         default: return "R9 load";
      endcase
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: act running exp finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release");

      // directed corners
      step(3'd1, 32'h10, 6'b000100, 0, '0, 1, "R2 masked zero-divide");
      step(3'd0, 32'h14, '0, 0, '0, 1, "R2 default pulse ends");
      step(3'd7, 32'h18, '0, 0, 6'b000000, 1, "R9 unmask all");
      step(3'd1, 32'h100, 6'b001000, 0, '0, 1, "R3 unmasked overflow arms");
      step(3'd3, 32'h104, '0, 0, '0, 1, "R5 non-waiting bypass");
      step(3'd4, 32'h108, '0, 0, '0, 1, "R5 state save bypass");
      step(3'd2, 32'h200, '0, 0, '0, 1, "R4 wait raises");
      step(3'd0, 32'h204, '0, 0, '0, 1, "R4 pulse single cycle");
      step(3'd1, 32'h300, 6'b010000, 0, '0, 1, "R3 underflow arms");
      step(3'd1, 32'h304, 6'b100000, 0, '0, 1, "R4 arith raises, errors ignored");
      step(3'd0, 32'h308, '0, 0, '0, 1, "R11 flags held after request");
      step(3'd5, 32'h30c, '0, 0, '0, 1, "R7 clear");
      step(3'd1, 32'h400, 6'b000010, 0, '0, 0, "R6 disabled reporting");
      step(3'd2, 32'h404, '0, 0, '0, 0, "R6 no request");
      step(3'd1, 32'h500, '0, 1, '0, 1, "R10 stack fault");
      step(3'd7, 32'h504, 6'b101010, 0, 6'b101010, 1, "R9 partial mask");
      step(3'd1, 32'h508, 6'b100001, 0, '0, 1, "R2/R3 mixed masked and unmasked");
      step(3'd6, 32'h50c, '0, 0, '0, 1, "R8 init drops pending");

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         int sel;
         logic [2:0] c;
         logic [NE-1:0] e;
         sel = $urandom_range(0, 19);
         if (sel < 8)       c = 3'd1;
         else if (sel < 10) c = 3'd2;
         else if (sel < 12) c = 3'd3;
         else if (sel < 13) c = 3'd4;
         else if (sel < 15) c = 3'd0;
         else if (sel < 16) c = 3'd5;
         else if (sel < 17) c = 3'd6;
         else               c = 3'd7;
         e = ($urandom_range(0, 2) == 0) ? NE'($urandom) : '0;
         step(c, $urandom, e, ($urandom_range(0, 9) == 0),
              NE'($urandom), ($urandom_range(0, 9) != 0), tag_of(c));
      end

      finish_run();
   end

endmodule